// File: doc/BRIEF.md
# Power Domain Gating Controller

This block decides, cycle by cycle, the power state of a chain of gateable logic domains (three by default, numbered 0 upward) and of two fixed domains: a top domain and an always-on backup domain. It takes the chip's sleep mode and a set of per-domain requests, and produces a 2-bit state code for each gateable domain, a ready flag per domain, on/off flags for the fixed domains and a permission flag for the low-power core regulator.

In the running and idle modes every gateable domain is active. In standby a domain drops to retention by itself unless something needs it. Something needs it when a peripheral inside has to keep running, when configuration pins it active, or when an event or DMA trigger wakes it while dynamic gating is enabled for it. Two override rules then apply. A linking option can pull higher domains up behind lower ones. A strict hierarchy keeps every lower-numbered domain active beneath an active one. In the deepest modes all gateable domains and the top domain are switched off. A domain leaving retention or off is marked not ready for a fixed wake-up delay, and requesting logic waits for its ready flag.

Top module: `pd_gate_ctrl`

## Requirements
- R1: After reset every gateable domain reports active (code 2'b10) and ready, `top_on` and `bkup_on` are 1 and `lpreg_ok` is 0.
- R2: Mode codes: 0 run, 1 idle, 2 standby, 3 backup, 4 off; codes 5 to 7 behave as run. In run or idle, every domain is active one clock after the mode is applied.
- R3: In standby with no request of any kind, every gateable domain is in retention (code 2'b01) one clock later and `lpreg_ok` is 1.
- R4: In standby, a domain whose bit is set in `run_req` or in `hold_act` stays active.
- R5: Whenever domain n is active, every domain numbered below n is also active; this rule is applied after linking.
- R6: Bit i of `trig_req` wakes domain i (only domains 0 and 1 by default) in standby only when bit i of `dyn_en` is set; when the trigger drops the domain returns to retention.
- R7: `link_cfg` encodes 0 none, 1 domain 0 pulls in domain 1, 2 domain 1 pulls in domain 2, 3 domain 0 pulls in domains 1 and 2.
- R8: In backup all gateable domains are off (code 2'b00) and `top_on` is 0 while `bkup_on` stays 1; in off mode `bkup_on` is also 0.
- R9: `lpreg_ok` is 1 only in standby, and then only when every gateable domain is in retention, or when `lp_allow` is 1 and `clk_req` is 0.
- R10: A domain that enters the active state has `dom_ready` low for exactly WAKE_CYCLES clocks, then high; a domain not active is never ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_mode | input | 3 | Sleep mode code (R2) |
| run_req | input | NUM_GDOM | Per-domain run-in-standby demand |
| trig_req | input | NUM_DYN | Per-domain event/DMA trigger |
| dyn_en | input | NUM_DYN | Per-domain dynamic-gating enable |
| hold_act | input | NUM_GDOM | Per-domain pin-active configuration |
| link_cfg | input | 2 | Domain-linking option (R7) |
| lp_allow | input | 1 | Permit low-power regulator with active domains when no clock is requested |
| clk_req | input | 1 | Some clock is being requested |
| dom_state | output | 2*NUM_GDOM | State code per domain, domain i at bits 2i+1:2i |
| dom_ready | output | NUM_GDOM | Domain active and its wake-up delay expired |
| top_on | output | 1 | Top domain powered |
| bkup_on | output | 1 | Backup domain powered |
| lpreg_ok | output | 1 | Low-power core regulator may be used |

## Verification
On every cycle the assertions check the domain hierarchy, the all-off outcome of the deep modes, the all-active outcome of run and idle, and the retention outcome of an undisturbed standby. They also check that the regulator flag is raised only under its two permitted conditions, that readiness implies the active state, and that a freshly woken domain is never immediately ready. Only the bench scenarios show the exact mapping of each linking option, the refusal of a trigger without its enable, the return of a domain to retention after its trigger, and the exact length of the wake-up delay.

// File: rtl/pdg_pkg.sv
package pdg_pkg;

   typedef enum logic [1:0] {
      PD_OFF = 2'b00,
      PD_RET = 2'b01,
      PD_ACT = 2'b10
   } pd_state_e;

   typedef enum logic [2:0] {
      MODE_RUN   = 3'd0,
      MODE_IDLE  = 3'd1,
      MODE_STBY  = 3'd2,
      MODE_BKUP  = 3'd3,
      MODE_OFF   = 3'd4
   } pd_mode_e;

   localparam logic [1:0] LINK_NONE  = 2'd0;
   localparam logic [1:0] LINK_0TO1  = 2'd1;
   localparam logic [1:0] LINK_1TO2  = 2'd2;
   localparam logic [1:0] LINK_0TO12 = 2'd3;

endpackage

// File: rtl/pdg_want.sv
module pdg_want
   import pdg_pkg::*;
#(
   parameter int NUM_GDOM = 3,
   parameter int NUM_DYN  = 2
) (
   input  logic [2:0]          sleep_mode,
   input  logic [NUM_GDOM-1:0] run_req,
   input  logic [NUM_DYN-1:0]  trig_req,
   input  logic [NUM_DYN-1:0]  dyn_en,
   input  logic [NUM_GDOM-1:0] hold_act,
   input  logic [1:0]          link_cfg,
   output pd_state_e           tgt_st [NUM_GDOM],
   output logic                top_nxt,
   output logic                bkup_nxt
);

   logic [NUM_GDOM-1:0] dyn_wake;
   logic [NUM_GDOM-1:0] keep;
   logic [NUM_GDOM-1:0] linked;
   logic [NUM_GDOM-1:0] hier;

   for (genvar i = 0; i < NUM_GDOM; i++) begin : g_dyn
      if (i < NUM_DYN) begin : g_gated
         assign dyn_wake[i] = trig_req[i] & dyn_en[i];
      end else begin : g_fixed
         assign dyn_wake[i] = 1'b0;
      end
   end

   assign keep = run_req | hold_act | dyn_wake;

   always_comb begin
      linked = keep;
      unique case (link_cfg)
         LINK_0TO1:  linked[1] = keep[1] | keep[0];
         LINK_1TO2:  linked[2] = keep[2] | keep[1];
         LINK_0TO12: begin
            linked[1] = keep[1] | keep[0];
            linked[2] = keep[2] | keep[0];
         end
         default: ;
      endcase
   end

   assign hier[NUM_GDOM-1] = linked[NUM_GDOM-1];
   for (genvar i = NUM_GDOM-2; i >= 0; i--) begin : g_hier
      assign hier[i] = linked[i] | hier[i+1];
   end

   always_comb begin
      top_nxt  = 1'b1;
      bkup_nxt = 1'b1;
      for (int i = 0; i < NUM_GDOM; i++) begin
         tgt_st[i] = PD_ACT;
      end
      unique case (sleep_mode)
         MODE_STBY: begin
            for (int i = 0; i < NUM_GDOM; i++) begin
               tgt_st[i] = hier[i] ? PD_ACT : PD_RET;
            end
         end
         MODE_BKUP: begin
            top_nxt = 1'b0;
            for (int i = 0; i < NUM_GDOM; i++) begin
               tgt_st[i] = PD_OFF;
            end
         end
         MODE_OFF: begin
            top_nxt  = 1'b0;
            bkup_nxt = 1'b0;
            for (int i = 0; i < NUM_GDOM; i++) begin
               tgt_st[i] = PD_OFF;
            end
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/pdg_dom_slot.sv
module pdg_dom_slot
   import pdg_pkg::*;
#(
   parameter int WAKE_CYCLES = 4,
   localparam int CNT_W = $clog2(WAKE_CYCLES + 1)
) (
   input  logic      clk,
   input  logic      rst_n,
   input  pd_state_e tgt,
   output pd_state_e state,
   output logic      ready
);

   logic [CNT_W-1:0] wake_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= PD_ACT;
         wake_cnt <= '0;
      end else begin
         state <= tgt;
         if (tgt != PD_ACT) begin
            wake_cnt <= '0;
         end else if (state != PD_ACT) begin
            wake_cnt <= CNT_W'(WAKE_CYCLES);
         end else if (wake_cnt != '0) begin
            wake_cnt <= wake_cnt - 1'b1;
         end
      end
   end

   assign ready = (state == PD_ACT) && (wake_cnt == '0);

   // R10: readiness only ever in the active state
   assert_ready_act_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> state == PD_ACT);

   // R10: a domain that has just switched on is not yet ready
   assert_wake_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state != PD_ACT && tgt == PD_ACT) |=> !ready);

endmodule

// File: rtl/pd_gate_ctrl.sv
module pd_gate_ctrl
   import pdg_pkg::*;
#(
   parameter int NUM_GDOM    = 3,
   parameter int NUM_DYN     = 2,
   parameter int WAKE_CYCLES = 4,
   localparam int ST_W = 2 * NUM_GDOM
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2:0]          sleep_mode,
   input  logic [NUM_GDOM-1:0] run_req,
   input  logic [NUM_DYN-1:0]  trig_req,
   input  logic [NUM_DYN-1:0]  dyn_en,
   input  logic [NUM_GDOM-1:0] hold_act,
   input  logic [1:0]          link_cfg,
   input  logic                lp_allow,
   input  logic                clk_req,
   output logic [ST_W-1:0]     dom_state,
   output logic [NUM_GDOM-1:0] dom_ready,
   output logic                top_on,
   output logic                bkup_on,
   output logic                lpreg_ok
);

   if (NUM_GDOM < 3) begin : g_bad_ndom
      $error("pd_gate_ctrl: NUM_GDOM must be at least 3 for the linking options");
   end
   if (NUM_DYN < 1 || NUM_DYN > NUM_GDOM) begin : g_bad_ndyn
      $error("pd_gate_ctrl: NUM_DYN must lie between 1 and NUM_GDOM");
   end
   if (WAKE_CYCLES < 1) begin : g_bad_wake
      $error("pd_gate_ctrl: WAKE_CYCLES must be at least 1");
   end

   pd_state_e tgt_st [NUM_GDOM];
   pd_state_e cur_st [NUM_GDOM];
   logic      top_nxt;
   logic      bkup_nxt;
   logic      all_ret_nxt;
   logic      lp_nxt;

   pdg_want #(
      .NUM_GDOM (NUM_GDOM),
      .NUM_DYN  (NUM_DYN)
   ) u_want (
      .sleep_mode (sleep_mode),
      .run_req    (run_req),
      .trig_req   (trig_req),
      .dyn_en     (dyn_en),
      .hold_act   (hold_act),
      .link_cfg   (link_cfg),
      .tgt_st     (tgt_st),
      .top_nxt    (top_nxt),
      .bkup_nxt   (bkup_nxt)
   );

   for (genvar i = 0; i < NUM_GDOM; i++) begin : g_slot
      pdg_dom_slot #(
         .WAKE_CYCLES (WAKE_CYCLES)
      ) u_slot (
         .clk   (clk),
         .rst_n (rst_n),
         .tgt   (tgt_st[i]),
         .state (cur_st[i]),
         .ready (dom_ready[i])
      );
      assign dom_state[2*i +: 2] = cur_st[i];
   end

   always_comb begin
      all_ret_nxt = 1'b1;
      for (int i = 0; i < NUM_GDOM; i++) begin
         if (tgt_st[i] != PD_RET) all_ret_nxt = 1'b0;
      end
   end

   assign lp_nxt = (sleep_mode == MODE_STBY) && (all_ret_nxt || (lp_allow && !clk_req));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         top_on   <= 1'b1;
         bkup_on  <= 1'b1;
         lpreg_ok <= 1'b0;
      end else begin
         top_on   <= top_nxt;
         bkup_on  <= bkup_nxt;
         lpreg_ok <= lp_nxt;
      end
   end

   logic any_act;
   logic all_ret;
   logic all_off;
   logic all_act;
   always_comb begin
      any_act = 1'b0;
      all_ret = 1'b1;
      all_off = 1'b1;
      all_act = 1'b1;
      for (int i = 0; i < NUM_GDOM; i++) begin
         if (cur_st[i] == PD_ACT) any_act = 1'b1;
         if (cur_st[i] != PD_RET) all_ret = 1'b0;
         if (cur_st[i] != PD_OFF) all_off = 1'b0;
         if (cur_st[i] != PD_ACT) all_act = 1'b0;
      end
   end

   for (genvar i = 1; i < NUM_GDOM; i++) begin : g_hier_chk
      assert_hier_R5: assert property (@(posedge clk) disable iff (!rst_n)
         cur_st[i] == PD_ACT |-> cur_st[i-1] == PD_ACT);
   end

   assert_deep_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_mode == MODE_BKUP || sleep_mode == MODE_OFF) |=> (all_off && !top_on));

   assert_bkup_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_mode != MODE_OFF) |=> bkup_on);

   assert_awake_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_mode == MODE_RUN || sleep_mode == MODE_IDLE || sleep_mode > MODE_OFF) |=> all_act);

   assert_quiet_ret_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_mode == MODE_STBY && run_req == '0 && hold_act == '0 && (trig_req & dyn_en) == '0)
      |=> (all_ret && lpreg_ok));

   assert_lpreg_R9: assert property (@(posedge clk) disable iff (!rst_n)
      lpreg_ok |-> (all_ret || (any_act && $past(lp_allow && !clk_req))));

endmodule

// File: tb/pd_gate_ctrl_tb.sv
module pd_gate_ctrl_tb;

   localparam int WAKE = 4;
   localparam int NV   = 22;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] sleep_mode = '0;
   logic [2:0] run_req = '0;
   logic [1:0] trig_req = '0;
   logic [1:0] dyn_en = '0;
   logic [2:0] hold_act = '0;
   logic [1:0] link_cfg = '0;
   logic       lp_allow = 1'b0;
   logic       clk_req = 1'b0;
   logic [5:0] dom_state;
   logic [2:0] dom_ready;
   logic       top_on, bkup_on, lpreg_ok;

   int n_vec = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   pd_gate_ctrl #(.NUM_GDOM(3), .NUM_DYN(2), .WAKE_CYCLES(WAKE)) u_dut (
      .clk (clk), .rst_n (rst_n), .sleep_mode (sleep_mode), .run_req (run_req),
      .trig_req (trig_req), .dyn_en (dyn_en), .hold_act (hold_act),
      .link_cfg (link_cfg), .lp_allow (lp_allow), .clk_req (clk_req),
      .dom_state (dom_state), .dom_ready (dom_ready), .top_on (top_on),
      .bkup_on (bkup_on), .lpreg_ok (lpreg_ok)
   );

   // {req, mode, run, trig, dyn, hold, link, lp_allow, clk_req, state, top, bkup, lp}
   localparam logic [29:0] VEC [NV] = '{
      {4'd2,  3'd0, 3'b000, 2'b00, 2'b00, 3'b000, 2'd0, 1'b0, 1'b0, 6'b101010, 3'b110}, // R2 run
      {4'd2,  3'd1, 3'b000, 2'b00, 2'b00, 3'b000, 2'd0, 1'b0, 1'b0, 6'b101010, 3'b110}, // R2 idle
      {4'd3,  3'd2, 3'b000, 2'b00, 2'b00, 3'b000, 2'd0, 1'b0, 1'b0, 6'b010101, 3'b111}, // R3 quiet standby
      {4'd4,  3'd2, 3'b001, 2'b00, 2'b00, 3'b000, 2'd0, 1'b0, 1'b0, 6'b010110, 3'b110}, // R4 run in d0
      {4'd5,  3'd2, 3'b100, 2'b00, 2'b00, 3'b000, 2'd0, 1'b0, 1'b0, 6'b101010, 3'b110}, // R5 d2 drags all
      {4'd5,  3'd2, 3'b010, 2'b00, 2'b00, 3'b000, 2'd0, 1'b0, 1'b0, 6'b011010, 3'b110}, // R5 d1 drags d0
      {4'd4,  3'd2, 3'b000, 2'b00, 2'b00, 3'b010, 2'd0, 1'b0, 1'b0, 6'b011010, 3'b110}, // R4 hold d1
      {4'd6,  3'd2, 3'b000, 2'b01, 2'b00, 3'b000, 2'd0, 1'b0, 1'b0, 6'b010101, 3'b111}, // R6 trig no enable
      {4'd6,  3'd2, 3'b000, 2'b01, 2'b01, 3'b000, 2'd0, 1'b0, 1'b0, 6'b010110, 3'b110}, // R6 trig d0
      {4'd6,  3'd2, 3'b000, 2'b10, 2'b10, 3'b000, 2'd0, 1'b0, 1'b0, 6'b011010, 3'b110}, // R6 trig d1
      {4'd6,  3'd2, 3'b000, 2'b10, 2'b01, 3'b000, 2'd0, 1'b0, 1'b0, 6'b010101, 3'b111}, // R6 wrong enable
      {4'd7,  3'd2, 3'b000, 2'b01, 2'b01, 3'b000, 2'd1, 1'b0, 1'b0, 6'b011010, 3'b110}, // R7 link 1
      {4'd7,  3'd2, 3'b010, 2'b00, 2'b00, 3'b000, 2'd2, 1'b0, 1'b0, 6'b101010, 3'b110}, // R7 link 2 from d1
      {4'd7,  3'd2, 3'b001, 2'b00, 2'b00, 3'b000, 2'd2, 1'b0, 1'b0, 6'b010110, 3'b110}, // R7 link 2 ignores d0
      {4'd7,  3'd2, 3'b001, 2'b00, 2'b00, 3'b000, 2'd3, 1'b0, 1'b0, 6'b101010, 3'b110}, // R7 link 3
      {4'd9,  3'd2, 3'b001, 2'b00, 2'b00, 3'b000, 2'd0, 1'b1, 1'b0, 6'b010110, 3'b111}, // R9 allow, no clock
      {4'd9,  3'd2, 3'b001, 2'b00, 2'b00, 3'b000, 2'd0, 1'b1, 1'b1, 6'b010110, 3'b110}, // R9 clock requested
      {4'd8,  3'd3, 3'b111, 2'b11, 2'b11, 3'b111, 2'd3, 1'b1, 1'b0, 6'b000000, 3'b010}, // R8 backup
      {4'd8,  3'd4, 3'b000, 2'b00, 2'b00, 3'b000, 2'd0, 1'b0, 1'b0, 6'b000000, 3'b000}, // R8 off
      {4'd2,  3'd6, 3'b000, 2'b00, 2'b00, 3'b000, 2'd0, 1'b0, 1'b0, 6'b101010, 3'b110}, // R2 spare code
      {4'd3,  3'd2, 3'b000, 2'b00, 2'b00, 3'b000, 2'd0, 1'b0, 1'b0, 6'b010101, 3'b111}, // R3 again
      {4'd6,  3'd2, 3'b000, 2'b00, 2'b11, 3'b000, 2'd0, 1'b0, 1'b0, 6'b010101, 3'b111}  // R6 back to retention
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 state", {26'd0, dom_state}, {26'b0, 6'b101010});
      check("R1 ready", {29'd0, dom_ready}, 32'd7);
      check("R1 flags", {29'd0, top_on, bkup_on, lpreg_ok}, 32'b110);
      rst_n = 1'b1;
      @(negedge clk);

      for (int k = 0; k < NV; k++) begin
         {sleep_mode, run_req, trig_req, dyn_en, hold_act, link_cfg, lp_allow, clk_req} = VEC[k][25:9];
         @(negedge clk);
         check($sformatf("R%0d vec%0d", VEC[k][29:26], k),
               {23'd0, dom_state, top_on, bkup_on, lpreg_ok}, {23'd0, VEC[k][8:0]});
      end

      // R10: retention domains not ready, then exact wake delay on return to run
      {run_req, trig_req, dyn_en, hold_act, link_cfg, lp_allow, clk_req} = '0;
      sleep_mode = 3'd2;
      @(negedge clk);
      check("R10 retention not ready", {29'd0, dom_ready}, 32'd0);
      sleep_mode = 3'd0;
      for (int c = 0; c < WAKE; c++) begin
         @(negedge clk);
         check($sformatf("R10 waking cycle %0d", c), {29'd0, dom_ready}, 32'd0);
      end
      @(negedge clk);
      check("R10 ready after delay", {29'd0, dom_ready}, 32'd7);

      // R10 and R6: only the triggered domain re-wakes; the others keep ready state of their level
      sleep_mode = 3'd2;
      dyn_en = 2'b01;
      trig_req = 2'b01;
      @(negedge clk);
      check("R6 d0 stays active", {26'd0, dom_state}, {26'b0, 6'b010110});
      check("R10 continuous d0 ready", {29'd0, dom_ready}, 32'd1);
      trig_req = 2'b00;
      @(negedge clk);
      check("R6 trigger dropped", {26'd0, dom_state}, {26'b0, 6'b010101});
      trig_req = 2'b01;
      @(negedge clk);
      check("R10 d0 rewake not ready", {29'd0, dom_ready}, 32'd0);
      repeat (WAKE) @(negedge clk);
      check("R10 d0 rewake ready", {29'd0, dom_ready}, 32'd1);

      // R8 then R1-style recovery through reset
      sleep_mode = 3'd4;
      @(negedge clk);
      check("R8 off ready", {29'd0, dom_ready}, 32'd0);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 reset recovery", {23'd0, dom_state, top_on, bkup_on, lpreg_ok}, {23'd0, 6'b101010, 3'b110});
      finish_run();
   end

endmodule